// File: doc/BRIEF.md
# Noise-Adaptive Hybrid 3x3 Denoising Filter

This block cleans one pixel per clock from a stream of ready-made 3x3 neighbourhoods of 8-bit grey pixels. For every neighbourhood it judges whether the centre pixel looks like salt-and-pepper damage or like ordinary small-amplitude noise. A multilevel median result and a weighted-mean result are computed side by side. The judgement then picks one of them through an output mux.

The judgement and both filter results pass through a fixed register pipeline, so all three meet in the same clock. A raster position counter, advanced only by accepted neighbourhoods, flags the outer ring of the frame. Pixels on that ring leave the block unchanged. An upstream line-buffer stage is expected to build the neighbourhoods and to assert the enable for exactly one frame's worth of them per frame.

Top module: `hybrid_filter`

## Requirements
- R1: One neighbourhood can be accepted on every clock, and `out_valid` is `in_valid` delayed by exactly three clocks.
- R2: A position counter walks the frame in raster order. It moves only on cycles with `in_valid` high: column 0..IMG_W-1 first, then the row, and it wraps to the origin after IMG_W*IMG_H accepted neighbourhoods. When the position is in the first or last row or column, the output equals the centre pixel.
- R3: For an interior position whose centre is 0 or 255, the output is the multilevel median.
- R4: For an interior position whose centre is neither 0 nor 255, the output is the multilevel median when |centre - multilevel median| is strictly greater than `thr`, and the weighted mean otherwise. `thr` is taken in the same cycle as the neighbourhood it applies to.
- R5: The weighted mean is (corners*1 + edge-adjacent pixels*2 + centre*4 + 8) >> 4, a rounded division by 16.
- R6: The multilevel median is the median of three values: the centre, the 5-point median of {up, left, centre, right, down}, and the 5-point median of the four diagonal corners plus the centre. Pixel (row r, column c) of the neighbourhood sits at bits [(3r+c)*8 +: 8] of `in_win`, so the centre is bits [39:32].
- R7: While `rst` is high and right after it, `out_valid` is 0 and `out_pix` is 0, and the position counter is at the frame origin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Neighbourhood on `in_win` is accepted this cycle |
| in_win | input | 72 | Nine 8-bit pixels, row-major, top-left in the low byte |
| thr | input | 8 | Deviation threshold for the noise judgement |
| out_valid | output | 1 | `out_pix` carries a filtered pixel |
| out_pix | output | 8 | Filtered pixel |

## Verification
Two decisions can fall in the same cycle. One is the boundary pass-through. The other is the impulse or threshold choice, which is made for every neighbourhood, including edge ones carrying 0 or 255 centres. The bench sends impulse and over-threshold centres across complete frames, so some of them land on the outer ring. There the pass-through must win and return the raw centre, while the same pattern one column inward must return the median. Idle cycles are also mixed into a frame, and the rings of the next frame must still fall in the right places, which shows that the counter holds during gaps and wraps at the frame end.

// File: rtl/hf_pkg.sv
package hf_pkg;

    localparam int PIX_W = 8;
    localparam int WIN_N = 9;
    localparam int CTR_IX = 4;
    localparam int SUM_W = PIX_W + 4;

    typedef logic [PIX_W-1:0] pix_t;
    typedef pix_t [WIN_N-1:0] win_t;
    typedef pix_t [4:0]       five_t;

    localparam pix_t PIX_MAX = '1;

    typedef enum logic [1:0] {
        SEL_MEAN   = 2'd0,
        SEL_MEDIAN = 2'd1,
        SEL_PASS   = 2'd2
    } sel_e;

    typedef struct packed {
        logic             valid;
        logic             edge_px;
        pix_t             centre;
        pix_t             thr;
        pix_t             med_plus;
        pix_t             med_diag;
        logic [SUM_W-1:0] wsum;
    } s1_t;

    typedef struct packed {
        logic valid;
        sel_e sel;
        pix_t centre;
        pix_t mlm;
        pix_t wmean;
    } s2_t;

    function automatic pix_t med3(pix_t a, pix_t b, pix_t c);
        pix_t lo, hi, mid;
        lo  = (a < b) ? a : b;
        hi  = (a < b) ? b : a;
        mid = (hi < c) ? hi : c;
        return (lo > mid) ? lo : mid;
    endfunction

    // rank selection: element with <=2 strictly below and >=3 at or below
    function automatic pix_t med5(five_t v);
        pix_t r;
        int   lt;
        int   le;
        r = v[0];
        for (int i = 0; i < 5; i++) begin
            lt = 0;
            le = 0;
            for (int j = 0; j < 5; j++) begin
                if (v[j] < v[i])  lt++;
                if (v[j] <= v[i]) le++;
            end
            if (lt <= 2 && le >= 3) r = v[i];
        end
        return r;
    endfunction

    function automatic logic [SUM_W-1:0] wsum9(win_t w);
        logic [SUM_W-1:0] s;
        s = '0;
        for (int i = 0; i < WIN_N; i++) begin
            if (i == CTR_IX)  s = s + (SUM_W'(w[i]) << 2);
            else if (i % 2)   s = s + (SUM_W'(w[i]) << 1);
            else              s = s + SUM_W'(w[i]);
        end
        return s;
    endfunction

endpackage

// File: rtl/hf_pos_counter.sv
module hf_pos_counter #(
    parameter int IMG_W = 8,
    parameter int IMG_H = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic edge_o
);
    localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1;
    localparam int ROW_W = (IMG_H > 1) ? $clog2(IMG_H) : 1;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_H - 1);

    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;

    always_ff @(posedge clk) begin
        if (rst) begin
            col <= '0;
            row <= '0;
        end else if (en) begin
            if (col == COL_LAST) begin
                col <= '0;
                row <= (row == ROW_LAST) ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    always_comb
        edge_o = (col == '0) || (col == COL_LAST) || (row == '0) || (row == ROW_LAST);

    // R2
    pos_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (col <= COL_LAST) && (row <= ROW_LAST));

    // R2
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (col == $past(col)) && (row == $past(row)));

endmodule

// File: rtl/hf_kernel_stage.sv
module hf_kernel_stage
    import hf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic valid_i,
    input  logic edge_i,
    input  win_t win_i,
    input  pix_t thr_i,
    output s1_t  q_o
);
    five_t plus_set;
    five_t diag_set;

    always_comb begin
        plus_set = {win_i[1], win_i[3], win_i[CTR_IX], win_i[5], win_i[7]};
        diag_set = {win_i[0], win_i[2], win_i[CTR_IX], win_i[6], win_i[8]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else begin
            q_o.valid    <= valid_i;
            q_o.edge_px  <= edge_i;
            q_o.centre   <= win_i[CTR_IX];
            q_o.thr      <= thr_i;
            q_o.med_plus <= med5(plus_set);
            q_o.med_diag <= med5(diag_set);
            q_o.wsum     <= wsum9(win_i);
        end
    end

endmodule

// File: rtl/hf_select_stage.sv
module hf_select_stage
    import hf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  s1_t  s1_i,
    output logic out_valid,
    output pix_t out_pix
);
    pix_t             mlm;
    pix_t             wmean;
    pix_t             diff;
    logic [SUM_W-1:0] rnd;
    logic             impulse;
    sel_e             sel;
    s2_t              s2;

    always_comb begin
        mlm     = med3(s1_i.med_plus, s1_i.med_diag, s1_i.centre);
        rnd     = s1_i.wsum + SUM_W'(8);
        wmean   = rnd[SUM_W-1:4];
        diff    = (s1_i.centre > mlm) ? (s1_i.centre - mlm) : (mlm - s1_i.centre);
        impulse = (s1_i.centre == '0) || (s1_i.centre == PIX_MAX);
        if (s1_i.edge_px)                   sel = SEL_PASS;
        else if (impulse || diff > s1_i.thr) sel = SEL_MEDIAN;
        else                                sel = SEL_MEAN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.valid  <= s1_i.valid;
            s2.sel    <= sel;
            s2.centre <= s1_i.centre;
            s2.mlm    <= mlm;
            s2.wmean  <= wmean;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s2.valid;
            case (s2.sel)
                SEL_PASS:   out_pix <= s2.centre;
                SEL_MEDIAN: out_pix <= s2.mlm;
                default:    out_pix <= s2.wmean;
            endcase
        end
    end

    // R2
    edge_pass_chk: assert property (@(posedge clk) disable iff (rst)
        s1_i.valid && s1_i.edge_px |=> ##1 (out_pix == $past(s1_i.centre, 2)));

    // R3
    impulse_median_chk: assert property (@(posedge clk) disable iff (rst)
        s1_i.valid && !s1_i.edge_px && impulse |=> ##1 (out_pix == $past(mlm, 2)));

    // R4
    over_thr_median_chk: assert property (@(posedge clk) disable iff (rst)
        s1_i.valid && !s1_i.edge_px && !impulse && (diff > s1_i.thr)
        |=> ##1 (out_pix == $past(mlm, 2)));

    // R5
    mean_path_chk: assert property (@(posedge clk) disable iff (rst)
        s1_i.valid && !s1_i.edge_px && !impulse && (diff <= s1_i.thr)
        |=> ##1 (out_pix == $past(wmean, 2)));

endmodule

// File: rtl/hybrid_filter.sv
module hybrid_filter
    import hf_pkg::*;
#(
    parameter int IMG_W = 8,
    parameter int IMG_H = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [WIN_N*PIX_W-1:0] in_win,
    input  logic [PIX_W-1:0]       thr,
    output logic                   out_valid,
    output logic [PIX_W-1:0]       out_pix
);
    localparam int LAT = 3;

    logic edge_now;
    s1_t  s1;
    win_t win;

    always_comb win = win_t'(in_win);

    hf_pos_counter #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H)
    ) u_pos (
        .clk    (clk),
        .rst    (rst),
        .en     (in_valid),
        .edge_o (edge_now)
    );

    hf_kernel_stage u_kern (
        .clk     (clk),
        .rst     (rst),
        .valid_i (in_valid),
        .edge_i  (edge_now),
        .win_i   (win),
        .thr_i   (thr),
        .q_o     (s1)
    );

    hf_select_stage u_sel (
        .clk       (clk),
        .rst       (rst),
        .s1_i      (s1),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= '0;
        else if (since_rst != 2'(LAT)) since_rst <= since_rst + 1'b1;
    end

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'(LAT)) |-> (out_valid == $past(in_valid, 3)));

    // R7
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && (out_pix == '0));

endmodule

// File: tb/tb_hybrid_filter.sv
module tb_hybrid_filter;

    localparam int W = 8;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [71:0] in_win = '0;
    logic [7:0]  thr = '0;
    logic        out_valid;
    logic [7:0]  out_pix;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] lcg = 32'h1234_5678;
    int bcol = 0;
    int brow = 0;

    logic       ev [3];
    logic [7:0] ep [3];
    string      et [3];

    always #10 clk = ~clk;

    hybrid_filter #(.IMG_W(W), .IMG_H(H)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_win    (in_win),
        .thr       (thr),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    function automatic logic [7:0] rnd8();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg[23:16];
    endfunction

    function automatic logic [7:0] m5(logic [7:0] a, logic [7:0] b, logic [7:0] c,
                                      logic [7:0] d, logic [7:0] e);
        logic [7:0] v [5];
        logic [7:0] t;
        v[0] = a; v[1] = b; v[2] = c; v[3] = d; v[4] = e;
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 4 - i; j++)
                if (v[j] > v[j+1]) begin t = v[j]; v[j] = v[j+1]; v[j+1] = t; end
        return v[2];
    endfunction

    function automatic logic [7:0] m3(logic [7:0] a, logic [7:0] b, logic [7:0] c);
        return m5(a, b, c, 8'd0, 8'd255);
    endfunction

    function automatic logic [7:0] px(logic [71:0] w, int i);
        return w[i*8 +: 8];
    endfunction

    // R6 multilevel median model
    function automatic logic [7:0] mlm_of(logic [71:0] w);
        logic [7:0] a, b;
        a = m5(px(w,1), px(w,3), px(w,4), px(w,5), px(w,7));
        b = m5(px(w,0), px(w,2), px(w,4), px(w,6), px(w,8));
        return m3(a, b, px(w,4));
    endfunction

    // R5 weighted mean model
    function automatic logic [7:0] mean_of(logic [71:0] w);
        int s;
        s = px(w,0) + px(w,2) + px(w,6) + px(w,8)
          + 2 * (px(w,1) + px(w,3) + px(w,5) + px(w,7)) + 4 * px(w,4);
        return 8'((s + 8) / 16);
    endfunction

    task automatic check(logic ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one clock: compare the oldest expectation, then drive a new neighbourhood
    task automatic send(logic v, logic [71:0] w, logic [7:0] t);
        logic [7:0] c, m, d;
        logic       edge_b;
        check(out_valid == ev[2], "R1 valid", int'(out_valid), int'(ev[2]));
        if (ev[2])
            check(out_pix == ep[2], et[2], int'(out_pix), int'(ep[2]));
        ev[2] = ev[1]; ep[2] = ep[1]; et[2] = et[1];
        ev[1] = ev[0]; ep[1] = ep[0]; et[1] = et[0];
        ev[0] = v;
        c = px(w, 4);
        m = mlm_of(w);
        d = (c > m) ? c - m : m - c;
        edge_b = (bcol == 0) || (bcol == W-1) || (brow == 0) || (brow == H-1);
        if (edge_b)                       begin ep[0] = c;          et[0] = "R2 edge";        end
        else if (c == 8'd0 || c == 8'hFF) begin ep[0] = m;          et[0] = "R3/R6 impulse";  end
        else if (d > t)                   begin ep[0] = m;          et[0] = "R4/R6 over thr"; end
        else                              begin ep[0] = mean_of(w); et[0] = "R5 mean";        end
        if (v) begin
            if (bcol == W-1) begin
                bcol = 0;
                brow = (brow == H-1) ? 0 : brow + 1;
            end else begin
                bcol++;
            end
        end
        in_valid = v;
        in_win   = w;
        thr      = t;
        @(negedge clk);
    endtask

    function automatic logic [71:0] near_flat(logic [7:0] base, logic [7:0] spread);
        logic [71:0] w;
        for (int i = 0; i < 9; i++)
            w[i*8 +: 8] = base + (rnd8() % (spread + 8'd1));
        return w;
    endfunction

    task automatic test_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R7
        check(out_valid == 1'b0, "R7 valid in reset", int'(out_valid), 0);
        check(out_pix == 8'd0, "R7 pixel in reset", int'(out_pix), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R7 valid after reset", int'(out_valid), 0);
        check(out_pix == 8'd0, "R7 pixel after reset", int'(out_pix), 0);
    endtask

    // R5, R2, R1: smooth frame with idle gaps that must not move the position
    task automatic test_smooth_gaps();
        int k = 0;
        while (k < W*H) begin
            if ((rnd8() % 4) == 0) begin
                send(1'b0, near_flat(8'd60, 8'd6), 8'd30);
            end else begin
                send(1'b1, near_flat(8'd60, 8'd6), 8'd30);
                k++;
            end
        end
    endtask

    // R3, R2: impulses everywhere, ring must pass them through
    task automatic test_impulse();
        logic [71:0] w;
        for (int k = 0; k < W*H; k++) begin
            w = near_flat(8'd120, 8'd20);
            w[39:32] = (k % 2) ? 8'hFF : 8'h00;
            send(1'b1, w, 8'd200);
        end
    endtask

    // R4: deviation sweeps across the threshold, threshold changes every cycle
    task automatic test_threshold();
        logic [71:0] w;
        logic [7:0]  t;
        for (int k = 0; k < W*H; k++) begin
            for (int i = 0; i < 9; i++) w[i*8 +: 8] = 8'd100;
            w[39:32] = 8'(100 + (k % 11));
            t = (k % 2) ? 8'd5 : 8'd6;
            send(1'b1, w, t);
        end
    endtask

    // R6, R4: unrestricted content and thresholds
    task automatic test_random();
        logic [71:0] w;
        for (int k = 0; k < W*H; k++) begin
            for (int i = 0; i < 9; i++) w[i*8 +: 8] = rnd8();
            send(1'b1, w, rnd8() % 8'd64);
        end
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin ev[i] = 1'b0; ep[i] = '0; et[i] = ""; end
        @(negedge clk);
        test_reset();
        test_smooth_gaps();
        test_impulse();
        test_threshold();
        test_random();
        for (int i = 0; i < 4; i++) send(1'b0, '0, '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule